// File: doc/BRIEF.md
# Hierarchical Configuration Access Router

This block takes configuration read and write requests and delivers each one to the device function it names. The devices sit on several bus segments. One segment is the primary bus, bus number 0. Each bridge adds one secondary segment, and the number of that secondary bus is programmed at run time. Each request carries a packed 24-bit address. The router splits that address into a bus number, a device/function number and a register offset. It then picks the segment and selects the matching device port.

The router learns each bridge's secondary bus number by watching the writes that pass through it to that bridge. The bridge's own register file is an ordinary attached port and still receives every one of those writes. The topology is fixed by parameters:
- which port is a bridge;
- which segment each port sits on;
- each port's device/function number, which may be left for automatic assignment at elaboration.

A request that hits nothing is dropped if it is a write. If it is a read, it returns all ones.

Top module: `cfg_route_top`

## Requirements
- R1: The request address is split into a bus number (bits 23:16), a device/function number (bits 15:8, with the slot in the upper 5 bits and the function in the lower 3 bits) and a register offset (bits 7:0). The offset is driven unchanged on `dev_offset`.
- R2: Bus number 0 always selects the primary segment (segment 0), whatever any bridge has been programmed to.
- R3: A nonzero bus number equal to bridge k's secondary bus number selects segment k+1. If two bridges hold the same number, the lower bridge index wins. All secondary bus numbers reset to 0, which is never matched.
- R4: Within the selected segment, a port is hit only if all 8 bits of its device/function number match. A different function number in the same slot does not hit.
- R5: A request that matches no segment or no port asserts no bit of `dev_sel`. A read that misses responds with 0xFFFFFFFF. At most one `dev_sel` bit is ever high.
- R6: An accepted write that hits a bridge port at offset 0x19 loads that bridge's secondary bus number from `req_wdata[7:0]`.
- R7: An accepted write that hits a bridge port at offset 0x18 with size code 1 (half) or 2 (word) loads the secondary bus number from `req_wdata[15:8]`. None of the following changes any secondary bus number:
  - a byte write (size code 0) at offset 0x18;
  - a write at any other offset;
  - a write to a port that is not a bridge;
  - a read.
- R8: Every accepted request that hits drives `dev_sel` for the hit port in the acceptance cycle, together with `dev_write`, `dev_size`, `dev_offset` and `dev_wdata`. This includes writes that are also snooped for a bridge.
- R9: A port whose configured device/function number is -1 is given, at elaboration, the first number counting up from `DEVFN_MIN` in steps of 8 that is free on its segment. With the defaults, port 1 gets 0x10 on segment 0 and port 3 gets 0x08 on segment 1.
- R10: `req_ready` is high except in the cycle after an acceptance. Each accepted request gives exactly one single-cycle `rsp_valid` pulse in the next cycle. For a read that hits, `rsp_rdata` carries the hit port's `dev_rdata` slice as sampled at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Router can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size: 0 byte, 1 half, 2 word |
| req_addr | input | 24 | Packed bus / device-function / offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Single-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, all ones on a miss |
| dev_sel | output | NUM_DEV | One-hot port strobe in the acceptance cycle |
| dev_write | output | 1 | Write flag forwarded to ports |
| dev_size | output | 2 | Size forwarded to ports |
| dev_offset | output | 8 | Register offset forwarded to ports |
| dev_wdata | output | 32 | Write data forwarded to ports |
| dev_rdata | input | NUM_DEV*32 | Per-port read data, port i in bits 32*i+31:32*i |

## Verification
Some properties hold on every cycle and the assertions check them there:
- the port strobe is at most one-hot;
- a strobe appears only with an accepted request;
- the response pulse lasts one cycle and always follows an acceptance;
- a missed read returns all ones;
- each secondary bus register moves only when a snooped write loads it, and then takes the right byte.

Other behaviour needs the bench's scenarios to show it:
- whether routing actually reaches the right port after a renumbering;
- that the automatic device/function assignment produced the expected numbers;
- that bus 0 stays primary;
- that a byte write at 0x18 and writes to ordinary ports leave the routing untouched.

// File: rtl/cfg_route_pkg.sv
package cfg_route_pkg;
   localparam int BUS_W   = 8;
   localparam int DEVFN_W = 8;
   localparam int OFS_W   = 8;
   localparam int ADDR_W  = BUS_W + DEVFN_W + OFS_W;
   localparam int DATA_W  = 32;
   localparam int SIZE_W  = 2;

   typedef enum logic [SIZE_W-1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } xfer_size_e;

   typedef struct packed {
      logic [BUS_W-1:0]   bus;
      logic [DEVFN_W-1:0] devfn;
      logic [OFS_W-1:0]   ofs;
   } cfg_addr_t;

   // bridge offsets whose writes renumber the secondary segment
   localparam logic [OFS_W-1:0] OFS_SEC_BYTE = 8'h19;
   localparam logic [OFS_W-1:0] OFS_BUS_PAIR = 8'h18;
endpackage

// File: rtl/cfg_bus_snoop.sv
module cfg_bus_snoop
   import cfg_route_pkg::*;
#(
   parameter int NUM_DEV = 4,
   parameter int NUM_BR  = 1,
   parameter int BR_DEV [NUM_BR] = '{0}
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_fire,
   input  logic [NUM_DEV-1:0]             dev_hit,
   input  logic [OFS_W-1:0]               ofs,
   input  logic [SIZE_W-1:0]              size,
   input  logic [DATA_W-1:0]              wdata,
   output logic [NUM_BR-1:0][BUS_W-1:0]   sec_bus
);
   for (genvar b = 0; b < NUM_BR; b++) begin : g_br
      logic br_wr, load_lo, load_hi;
      assign br_wr   = wr_fire && dev_hit[BR_DEV[b]];
      assign load_lo = br_wr && (ofs == OFS_SEC_BYTE);
      assign load_hi = br_wr && (ofs == OFS_BUS_PAIR) && (size != SZ_BYTE);

      always_ff @(posedge clk) begin
         if (!rst_n)       sec_bus[b] <= '0;
         else if (load_lo) sec_bus[b] <= wdata[7:0];
         else if (load_hi) sec_bus[b] <= wdata[15:8];
      end

      // R6: offset 0x19 write loads the low data byte
      a_r6_low_byte_load: assert property (@(posedge clk) disable iff (!rst_n)
         load_lo |=> sec_bus[b] == $past(wdata[7:0]));
      // R7: half/word write at 0x18 loads data bits 15:8
      a_r7_pair_load: assert property (@(posedge clk) disable iff (!rst_n)
         load_hi |=> sec_bus[b] == $past(wdata[15:8]));
      // R7: without a snooped write the bus number holds
      a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
         !(br_wr && (ofs == OFS_SEC_BYTE || (ofs == OFS_BUS_PAIR && size != SZ_BYTE)))
            |=> $stable(sec_bus[b]));
   end
endmodule

// File: rtl/cfg_target_decode.sv
module cfg_target_decode
   import cfg_route_pkg::*;
#(
   parameter int NUM_DEV   = 4,
   parameter int NUM_BR    = 1,
   parameter int DEVFN_MIN = 8,
   parameter int DEV_SEG [NUM_DEV] = '{0, 0, 1, 1},
   parameter int DEV_FN  [NUM_DEV] = '{8, -1, 0, -1}
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [BUS_W-1:0]              bus,
   input  logic [DEVFN_W-1:0]            devfn,
   input  logic [NUM_BR-1:0][BUS_W-1:0]  sec_bus,
   output logic [NUM_DEV-1:0]            dev_hit
);
   localparam int NUM_SEG  = NUM_BR + 1;
   localparam int DEVFN_LIM = 1 << DEVFN_W;

   // elaboration-time assignment of ports left at -1
   function automatic int devfn_of(int idx);
      int res [NUM_DEV];
      for (int i = 0; i < NUM_DEV; i++) res[i] = DEV_FN[i];
      for (int i = 0; i <= idx; i++) begin
         if (DEV_FN[i] < 0) begin
            for (int c = DEVFN_MIN; c < DEVFN_LIM; c += 8) begin
               if (res[i] < 0) begin
                  bit taken = 1'b0;
                  for (int j = 0; j < NUM_DEV; j++)
                     if (j != i && DEV_SEG[j] == DEV_SEG[i] && res[j] == c) taken = 1'b1;
                  if (!taken) res[i] = c;
               end
            end
         end
      end
      return res[idx];
   endfunction

   logic [NUM_SEG-1:0] seg_sel;
   always_comb begin
      logic found;
      found   = 1'b0;
      seg_sel = '0;
      if (bus == '0) seg_sel[0] = 1'b1;
      else begin
         for (int b = 0; b < NUM_BR; b++) begin
            if (!found && sec_bus[b] == bus) begin
               seg_sel[b+1] = 1'b1;
               found = 1'b1;
            end
         end
      end
   end

   for (genvar i = 0; i < NUM_DEV; i++) begin : g_dev
      localparam int FN = devfn_of(i);
      if (FN < 0 || FN >= DEVFN_LIM) begin : g_bad_fn
         $error("port %0d has no valid device/function number", i);
      end
      if (DEV_SEG[i] < 0 || DEV_SEG[i] >= NUM_SEG) begin : g_bad_seg
         $error("port %0d sits on a segment that does not exist", i);
      end
      assign dev_hit[i] = seg_sel[DEV_SEG[i]] && (devfn == DEVFN_W'(FN));
   end

   // R5: never more than one port hit
   a_r5_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dev_hit));
   // R2: bus 0 never routes behind a bridge
   a_r2_primary_only: assert property (@(posedge clk) disable iff (!rst_n)
      (bus == '0) |-> seg_sel == NUM_SEG'(1));
endmodule

// File: rtl/cfg_route_top.sv
module cfg_route_top
   import cfg_route_pkg::*;
#(
   parameter int NUM_DEV   = 4,
   parameter int NUM_BR    = 1,
   parameter int DEVFN_MIN = 8,
   parameter int DEV_SEG [NUM_DEV] = '{0, 0, 1, 1},
   parameter int DEV_FN  [NUM_DEV] = '{8, -1, 0, -1},
   parameter int BR_DEV  [NUM_BR]  = '{0}
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   output logic                      req_ready,
   input  logic                      req_write,
   input  logic [1:0]                req_size,
   input  logic [23:0]               req_addr,
   input  logic [31:0]               req_wdata,
   output logic                      rsp_valid,
   output logic [31:0]               rsp_rdata,
   output logic [NUM_DEV-1:0]        dev_sel,
   output logic                      dev_write,
   output logic [1:0]                dev_size,
   output logic [7:0]                dev_offset,
   output logic [31:0]               dev_wdata,
   input  logic [NUM_DEV*32-1:0]     dev_rdata
);
   if (NUM_DEV < 1 || NUM_BR < 1) begin : g_bad_counts
      $error("at least one port and one bridge are required");
   end
   if (ADDR_W != 24 || DATA_W != 32) begin : g_bad_widths
      $error("port widths assume a 24-bit address and 32-bit data");
   end
   for (genvar b = 0; b < NUM_BR; b++) begin : g_chk_br
      if (BR_DEV[b] < 0 || BR_DEV[b] >= NUM_DEV) begin : g_bad_br
         $error("bridge %0d names a port that does not exist", b);
      end
   end

   cfg_addr_t                  a;
   logic                       accept;
   logic [NUM_DEV-1:0]         dev_hit;
   logic [NUM_BR-1:0][BUS_W-1:0] sec_bus;
   logic [DATA_W-1:0]          rd_mux;

   assign a         = req_addr;
   assign req_ready = !rsp_valid;
   assign accept    = req_valid && req_ready;

   cfg_target_decode #(
      .NUM_DEV(NUM_DEV), .NUM_BR(NUM_BR), .DEVFN_MIN(DEVFN_MIN),
      .DEV_SEG(DEV_SEG), .DEV_FN(DEV_FN)
   ) u_decode (
      .clk(clk), .rst_n(rst_n), .bus(a.bus), .devfn(a.devfn),
      .sec_bus(sec_bus), .dev_hit(dev_hit)
   );

   cfg_bus_snoop #(
      .NUM_DEV(NUM_DEV), .NUM_BR(NUM_BR), .BR_DEV(BR_DEV)
   ) u_snoop (
      .clk(clk), .rst_n(rst_n), .wr_fire(accept && req_write),
      .dev_hit(dev_hit), .ofs(a.ofs), .size(req_size), .wdata(req_wdata),
      .sec_bus(sec_bus)
   );

   assign dev_sel    = accept ? dev_hit : '0;
   assign dev_write  = req_write;
   assign dev_size   = req_size;
   assign dev_offset = a.ofs;
   assign dev_wdata  = req_wdata;

   always_comb begin
      rd_mux = '1;
      for (int i = 0; i < NUM_DEV; i++)
         if (dev_hit[i]) rd_mux = dev_rdata[i*DATA_W +: DATA_W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= accept;
         if (accept) rsp_rdata <= req_write ? '0 : rd_mux;
      end
   end

   // R10: response pulse is exactly one cycle wide
   a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
   // R10: every response follows an accepted request
   a_r10_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rsp_valid) |-> $past(req_valid && req_ready));
   // R8: a port strobe only with an accepted request
   a_r8_strobe_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_sel != '0) |-> (req_valid && req_ready));
   // R5: a read that hit nothing returns all ones
   a_r5_miss_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !req_write && dev_hit == '0) |=> rsp_rdata == '1);
endmodule

// File: tb/tb_cfg_route_top.sv
module tb_cfg_route_top;
   localparam int NUM_DEV = 4;

   logic clk = 1'b0;
   logic rst_n;
   logic req_valid, req_ready, req_write;
   logic [1:0]  req_size;
   logic [23:0] req_addr;
   logic [31:0] req_wdata;
   logic rsp_valid;
   logic [31:0] rsp_rdata;
   logic [NUM_DEV-1:0] dev_sel;
   logic dev_write;
   logic [1:0] dev_size;
   logic [7:0] dev_offset;
   logic [31:0] dev_wdata;
   logic [NUM_DEV*32-1:0] dev_rdata;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;   // 125 MHz

   cfg_route_top dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
      .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .dev_sel(dev_sel), .dev_write(dev_write), .dev_size(dev_size),
      .dev_offset(dev_offset), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata)
   );

   // port models: read data tags the port number and the offset
   for (genvar i = 0; i < NUM_DEV; i++) begin : g_port
      assign dev_rdata[i*32 +: 32] = {16'hC0DE, 8'(i), dev_offset};
   end

   function automatic logic [31:0] tag(int port, logic [7:0] ofs);
      return {16'hC0DE, 8'(port), ofs};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // one transaction; returns strobe seen at acceptance and response data
   task automatic xfer(input bit wr, input logic [1:0] sz, input logic [23:0] addr,
                       input logic [31:0] wd, output logic [NUM_DEV-1:0] sel,
                       output logic [31:0] rd, output bit fwd_ok);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = addr; req_wdata = wd;
      #1;
      sel = dev_sel;
      fwd_ok = (dev_write == wr) && (dev_size == sz) && (dev_offset == addr[7:0])
               && (dev_wdata == wd) && (req_ready == 1'b1);
      @(negedge clk);
      req_valid = 1'b0;
      chk(rsp_valid == 1'b1, "R10 rsp_valid after accept", 32'(rsp_valid), 1);
      chk(req_ready == 1'b0, "R10 ready low during response", 32'(req_ready), 0);
      rd = rsp_rdata;
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R10 single-cycle pulse", 32'(rsp_valid), 0);
   endtask

   task automatic rd_expect(input logic [23:0] addr, input int port, input string req);
      logic [NUM_DEV-1:0] sel; logic [31:0] rd; bit f;
      logic [NUM_DEV-1:0] esel;
      logic [31:0] erd;
      esel = (port < 0) ? '0 : NUM_DEV'(1) << port;
      erd  = (port < 0) ? 32'hFFFF_FFFF : tag(port, addr[7:0]);
      xfer(1'b0, 2'd2, addr, 32'h0, sel, rd, f);
      chk(sel == esel, req, 32'(sel), 32'(esel));
      chk(rd == erd, req, rd, erd);
   endtask

   task automatic wr_expect(input logic [1:0] sz, input logic [23:0] addr,
                            input logic [31:0] wd, input int port, input string req);
      logic [NUM_DEV-1:0] sel; logic [31:0] rd; bit f;
      logic [NUM_DEV-1:0] esel;
      esel = (port < 0) ? '0 : NUM_DEV'(1) << port;
      xfer(1'b1, sz, addr, wd, sel, rd, f);
      chk(sel == esel, req, 32'(sel), 32'(esel));
      chk(f, "R8 fields forwarded", 32'(f), 1);
   endtask

   task automatic t_reset;
      chk(rsp_valid == 1'b0, "R10 reset rsp_valid", 32'(rsp_valid), 0);
      chk(req_ready == 1'b1, "R10 reset ready", 32'(req_ready), 1);
      chk(dev_sel == '0, "R5 reset no strobe", 32'(dev_sel), 0);
   endtask

   task automatic t_primary;
      rd_expect(24'h00_08_10, 0, "R2 bus0 port0 read");
      rd_expect(24'h00_10_04, 1, "R9 auto devfn 0x10 on bus0");
      rd_expect(24'h00_09_10, -1, "R4 function mismatch misses");
      rd_expect(24'h00_18_00, -1, "R5 empty devfn reads ones");
      rd_expect(24'h05_00_00, -1, "R3 unassigned bus misses");
      rd_expect(24'h00_00_3C, -1, "R1 slot0 on bus0 empty");
   endtask

   task automatic t_low_byte;
      wr_expect(2'd0, 24'h00_08_19, 32'h0000_0005, 0, "R6 bridge write strobed");
      rd_expect(24'h05_00_20, 2, "R6 bus5 reaches port2");
      rd_expect(24'h05_08_24, 3, "R9 auto devfn 0x08 behind bridge");
      rd_expect(24'h00_08_00, 0, "R2 bus0 still primary");
   endtask

   task automatic t_pair;
      wr_expect(2'd1, 24'h00_08_18, 32'h0000_0701, 0, "R7 half write at 0x18");
      rd_expect(24'h07_00_08, 2, "R7 bus7 reaches port2");
      rd_expect(24'h05_00_08, -1, "R7 old bus5 now misses");
      wr_expect(2'd0, 24'h00_08_18, 32'h0000_0900, 0, "R7 byte write at 0x18");
      rd_expect(24'h07_00_0C, 2, "R7 byte write ignored");
      wr_expect(2'd2, 24'h00_10_19, 32'h0000_0003, 1, "R7 non-bridge write");
      rd_expect(24'h07_08_0C, 3, "R7 non-bridge write ignored");
      rd_expect(24'h03_00_00, -1, "R7 bus3 not created");
      wr_expect(2'd2, 24'h00_08_1A, 32'h0000_0B0B, 0, "R7 other offset write");
      rd_expect(24'h07_00_10, 2, "R7 other offset ignored");
      wr_expect(2'd2, 24'h00_08_18, 32'h0000_0B00, 0, "R7 word write at 0x18");
      rd_expect(24'h0B_00_14, 2, "R7 word write sets bus 11");
   endtask

   task automatic t_miss_write;
      wr_expect(2'd2, 24'h00_30_19, 32'h0000_0055, -1, "R5 write to empty dropped");
      rd_expect(24'h0B_00_18, 2, "R5 dropped write left routing");
      wr_expect(2'd2, 24'h00_08_19, 32'h0000_0000, 0, "R3 bridge set to 0");
      rd_expect(24'h00_00_00, -1, "R3 bus0 never reaches secondary");
   endtask

   initial begin
      #(8 * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_size = 2'd0;
      req_addr = '0; req_wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_primary();
      t_low_byte();
      t_pair();
      t_miss_write();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule